// File: doc/BRIEF.md
# Exception Entry Prioritizer

This block sits beside a processor core's control logic and decides which exception to enter. Each clock it looks at seven request lines: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. The two interrupt lines are first filtered by the disable bits of the current status word. The highest-ranked request that remains wins.

One clock later the block gives the outcome as a registered bundle. A take strobe marks the entry. Alongside it come the vector address to fetch from, the mode the core must switch to, and the new interrupt-disable bits. The block also gives the complete status word to load, and the old status word and return address that the core stores in the target mode's banked registers.

The register file, fetch and the exception-return path stay in the core. This block only computes the entry.

Top module: `exc_vector_unit`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, every output is zero.
- R2: A request that is not masked, sampled at a rising edge, gives `take_o` = 1 after that edge and visible until the next one. A cycle with no eligible request gives `take_o` = 0, and every other output is then zero as well.
- R3: Vector offsets: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R4: Rank from highest to lowest: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt.
- R5: Target mode in the 5-bit mode field: reset and software interrupt 0x13 (supervisor); fast interrupt 0x11; normal interrupt 0x12; both aborts 0x17; undefined 0x1B.
- R6: A normal-interrupt request is ignored while status bit 7 is set. A fast-interrupt request is ignored while status bit 6 is set. A lower-ranked request then wins, or no entry happens.
- R7: The new status word keeps bits 31:8 of the old word and clears bit 5 (16-bit instruction state). It sets bit 7, and sets bit 6 for reset and fast interrupt, copying it otherwise. Bits 4:0 hold the target mode. `irq_mask_o` and `fiq_mask_o` equal new bits 7 and 6.
- R8: For every cause except reset, `save_en_o` = 1, `saved_psr_o` is the status word sampled with the request, and `link_o` is the sampled return address.
- R9: A reset entry gives `save_en_o` = 0, `saved_psr_o` = 0 and `link_o` = 0.
- R10: When undefined and software interrupt are requested together with nothing higher, undefined is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_reset_i | input | 1 | Reset exception request |
| req_undef_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software interrupt request |
| req_pabt_i | input | 1 | Prefetch abort request |
| req_dabt_i | input | 1 | Data abort request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_fiq_i | input | 1 | Fast interrupt request |
| psr_i | input | 32 | Current status word |
| ret_addr_i | input | ADDR_W | Return address for the link value |
| take_o | output | 1 | Exception entry strobe |
| vector_o | output | ADDR_W | Vector address |
| mode_o | output | 5 | Mode to enter |
| irq_mask_o | output | 1 | New normal-interrupt disable bit |
| fiq_mask_o | output | 1 | New fast-interrupt disable bit |
| new_psr_o | output | 32 | Status word to load |
| save_en_o | output | 1 | Write the saved status and link registers |
| saved_psr_o | output | 32 | Value for the saved status register |
| link_o | output | ADDR_W | Value for the link register |

## Verification
The assertions check on every cycle the properties that a single cycle can show. These are:
- at most one internal winner;
- a strobe only after an eligible request;
- aligned vectors;
- the fixed bits of the new status word;
- the pairing of vector and mode;
- the saved copies;
- no interrupt entry while it was masked;
- a software-interrupt entry never beating a concurrent undefined request.

The full rank order between every pair, the exact vector and mode of each cause, and masking that hands the win to a lower cause need the bench's directed scenarios. Each scenario sets up a chosen set of requests and status words and compares the result with a model written independently.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int PSR_W  = 32;
  localparam int MODE_W = 5;
  localparam int NSRC   = 7;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int BIT_I  = 7;
  localparam int BIT_F  = 6;
  localparam int BIT_T  = 5;

  // index is the rank: 0 wins over everything
  typedef enum logic [IDX_W-1:0] {
    SRC_RESET = 3'd0,
    SRC_DABT  = 3'd1,
    SRC_FIQ   = 3'd2,
    SRC_IRQ   = 3'd3,
    SRC_PABT  = 3'd4,
    SRC_UNDEF = 3'd5,
    SRC_SWI   = 3'd6
  } src_e;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } mode_e;

  function automatic logic [7:0] vec_offset(src_e s);
    case (s)
      SRC_RESET: return 8'h00;
      SRC_UNDEF: return 8'h04;
      SRC_SWI:   return 8'h08;
      SRC_PABT:  return 8'h0C;
      SRC_DABT:  return 8'h10;
      SRC_IRQ:   return 8'h18;
      SRC_FIQ:   return 8'h1C;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic mode_e mode_of(src_e s);
    case (s)
      SRC_FIQ:             return MODE_FIQ;
      SRC_IRQ:             return MODE_IRQ;
      SRC_PABT, SRC_DABT:  return MODE_ABT;
      SRC_UNDEF:           return MODE_UND;
      default:             return MODE_SVC;
    endcase
  endfunction

  function automatic logic [PSR_W-1:0] entry_psr(logic [PSR_W-1:0] old, src_e s);
    logic [PSR_W-1:0] r;
    r = old;
    r[BIT_T] = 1'b0;
    r[BIT_I] = 1'b1;
    if (s == SRC_RESET || s == SRC_FIQ) r[BIT_F] = 1'b1;
    r[MODE_W-1:0] = mode_of(s);
    return r;
  endfunction
endpackage

// File: rtl/exc_vec_gate.sv
module exc_vec_gate
  import exc_vec_pkg::*;
(
  input  logic [NSRC-1:0] raw_req,
  input  logic            irq_off,
  input  logic            fiq_off,
  output logic [NSRC-1:0] ok_req
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == int'(SRC_IRQ)) begin : g_irq
      assign ok_req[g] = raw_req[g] & ~irq_off;
    end else if (g == int'(SRC_FIQ)) begin : g_fiq
      assign ok_req[g] = raw_req[g] & ~fiq_off;
    end else begin : g_pass
      assign ok_req[g] = raw_req[g];
    end
  end
endmodule

// File: rtl/exc_vec_pick.sv
module exc_vec_pick
  import exc_vec_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  output logic [NSRC-1:0]  onehot,
  output logic [IDX_W-1:0] idx
);
  // lowest index wins; scan from the bottom rank upward
  always_comb begin
    onehot = '0;
    idx    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        onehot    = '0;
        onehot[i] = 1'b1;
        idx       = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/exc_vec_stage.sv
module exc_vec_stage
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  src_e              src,
  input  logic [PSR_W-1:0]  psr,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic              take,
  output logic [ADDR_W-1:0] vector,
  output logic [MODE_W-1:0] mode,
  output logic              irq_mask,
  output logic              fiq_mask,
  output logic [PSR_W-1:0]  new_psr,
  output logic              save_en,
  output logic [PSR_W-1:0]  saved_psr,
  output logic [ADDR_W-1:0] link
);
  logic [PSR_W-1:0] nxt_psr;
  logic             is_rst;

  assign nxt_psr = entry_psr(psr, src);
  assign is_rst  = (src == SRC_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take      <= 1'b0;
      vector    <= '0;
      mode      <= '0;
      irq_mask  <= 1'b0;
      fiq_mask  <= 1'b0;
      new_psr   <= '0;
      save_en   <= 1'b0;
      saved_psr <= '0;
      link      <= '0;
    end else if (hit) begin
      take      <= 1'b1;
      vector    <= ADDR_W'(vec_offset(src));
      mode      <= mode_of(src);
      irq_mask  <= nxt_psr[BIT_I];
      fiq_mask  <= nxt_psr[BIT_F];
      new_psr   <= nxt_psr;
      save_en   <= ~is_rst;
      saved_psr <= is_rst ? '0 : psr;
      link      <= is_rst ? '0 : ret_addr;
    end else begin
      take      <= 1'b0;
      vector    <= '0;
      mode      <= '0;
      irq_mask  <= 1'b0;
      fiq_mask  <= 1'b0;
      new_psr   <= '0;
      save_en   <= 1'b0;
      saved_psr <= '0;
      link      <= '0;
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_reset_i,
  input  logic              req_undef_i,
  input  logic              req_swi_i,
  input  logic              req_pabt_i,
  input  logic              req_dabt_i,
  input  logic              req_irq_i,
  input  logic              req_fiq_i,
  input  logic [31:0]       psr_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [4:0]        mode_o,
  output logic              irq_mask_o,
  output logic              fiq_mask_o,
  output logic [31:0]       new_psr_o,
  output logic              save_en_o,
  output logic [31:0]       saved_psr_o,
  output logic [ADDR_W-1:0] link_o
);
  logic [NSRC-1:0]  raw_req;
  logic [NSRC-1:0]  elig_req;
  logic [NSRC-1:0]  win_onehot;
  logic [IDX_W-1:0] win_idx;
  logic             win_valid;

  // bit position = rank
  assign raw_req = {req_swi_i, req_undef_i, req_pabt_i, req_irq_i,
                    req_fiq_i, req_dabt_i, req_reset_i};

  exc_vec_gate u_gate (
    .raw_req (raw_req),
    .irq_off (psr_i[BIT_I]),
    .fiq_off (psr_i[BIT_F]),
    .ok_req  (elig_req)
  );

  exc_vec_pick u_pick (
    .req    (elig_req),
    .onehot (win_onehot),
    .idx    (win_idx)
  );

  assign win_valid = |win_onehot;

  exc_vec_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (win_valid),
    .src       (src_e'(win_idx)),
    .psr       (psr_i),
    .ret_addr  (ret_addr_i),
    .take      (take_o),
    .vector    (vector_o),
    .mode      (mode_o),
    .irq_mask  (irq_mask_o),
    .fiq_mask  (fiq_mask_o),
    .new_psr   (new_psr_o),
    .save_en   (save_en_o),
    .saved_psr (saved_psr_o),
    .link      (link_o)
  );
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_reset_i,
  input logic              req_undef_i,
  input logic              req_swi_i,
  input logic              req_pabt_i,
  input logic              req_dabt_i,
  input logic              req_irq_i,
  input logic              req_fiq_i,
  input logic [31:0]       psr_i,
  input logic [ADDR_W-1:0] ret_addr_i,
  input logic              take_o,
  input logic [ADDR_W-1:0] vector_o,
  input logic [4:0]        mode_o,
  input logic [31:0]       new_psr_o,
  input logic              save_en_o,
  input logic [31:0]       saved_psr_o,
  input logic [ADDR_W-1:0] link_o,
  input logic [6:0]        win_onehot
);
  logic any_elig;
  assign any_elig = req_reset_i | req_dabt_i | req_pabt_i | req_undef_i | req_swi_i
                  | (req_fiq_i & ~psr_i[6]) | (req_irq_i & ~psr_i[7]);

  AST_TAKE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(any_elig)); // R2
  AST_CAUSE_GIVES_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    any_elig |=> take_o); // R2
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot)); // R4
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> vector_o[1:0] == 2'b00); // R3
  AST_IRQ_VEC_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == ADDR_W'(8'h18)) |-> mode_o == 5'h12); // R5
  AST_IRQ_NOT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == ADDR_W'(8'h18)) |-> !$past(psr_i[7])); // R6
  AST_ENTRY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (new_psr_o[7] && !new_psr_o[5] && new_psr_o[4:0] == mode_o)); // R7
  AST_SAVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && save_en_o) |-> (saved_psr_o == $past(psr_i) && link_o == $past(ret_addr_i))); // R8
  AST_RESET_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == '0) |-> (!save_en_o && link_o == '0 && mode_o == 5'h13)); // R9
  AST_SWI_YIELDS_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == ADDR_W'(8'h08)) |-> !$past(req_undef_i)); // R10
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_reset_i (req_reset_i),
  .req_undef_i (req_undef_i),
  .req_swi_i   (req_swi_i),
  .req_pabt_i  (req_pabt_i),
  .req_dabt_i  (req_dabt_i),
  .req_irq_i   (req_irq_i),
  .req_fiq_i   (req_fiq_i),
  .psr_i       (psr_i),
  .ret_addr_i  (ret_addr_i),
  .take_o      (take_o),
  .vector_o    (vector_o),
  .mode_o      (mode_o),
  .new_psr_o   (new_psr_o),
  .save_en_o   (save_en_o),
  .saved_psr_o (saved_psr_o),
  .link_o      (link_o),
  .win_onehot  (win_onehot)
);

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_reset_i = 0, req_undef_i = 0, req_swi_i = 0, req_pabt_i = 0;
  logic        req_dabt_i = 0, req_irq_i = 0, req_fiq_i = 0;
  logic [31:0] psr_i = 32'h0000_0010;
  logic [31:0] ret_addr_i = '0;
  logic        take_o, irq_mask_o, fiq_mask_o, save_en_o;
  logic [31:0] vector_o, new_psr_o, saved_psr_o, link_o;
  logic [4:0]  mode_o;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  exc_vector_unit #(.ADDR_W(32)) u_dut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // bench bit order: 0 reset,1 undef,2 swi,3 pabt,4 dabt,5 irq,6 fiq
  function automatic int model_pick(bit [6:0] r, logic [31:0] p);
    if (r[0]) return 0;
    if (r[4]) return 4;
    if (r[6] && !p[6]) return 6;
    if (r[5] && !p[7]) return 5;
    if (r[3]) return 3;
    if (r[1]) return 1;
    if (r[2]) return 2;
    return -1;
  endfunction

  function automatic logic [31:0] model_vec(int c);
    logic [31:0] v [7] = '{32'h00, 32'h04, 32'h08, 32'h0C, 32'h10, 32'h18, 32'h1C};
    return v[c];
  endfunction

  function automatic logic [4:0] model_mode(int c);
    logic [4:0] m [7] = '{5'h13, 5'h1B, 5'h13, 5'h17, 5'h17, 5'h12, 5'h11};
    return m[c];
  endfunction

  task automatic run_case(string tag, bit [6:0] r, logic [31:0] p, logic [31:0] ra);
    int c;
    logic [31:0] ep;
    @(negedge clk);
    {req_fiq_i, req_irq_i, req_dabt_i, req_pabt_i, req_swi_i, req_undef_i, req_reset_i} = r;
    psr_i = p;
    ret_addr_i = ra;
    @(negedge clk);
    c = model_pick(r, p);
    if (c < 0) begin
      chk(tag, "take idle", {31'b0, take_o}, 32'd0);
      chk(tag, "vector idle", vector_o, 32'd0);
      chk(tag, "save_en idle", {31'b0, save_en_o}, 32'd0);
    end else begin
      ep = (p & ~32'h3F) | (p & 32'h40) | 32'h80 | {27'b0, model_mode(c)};
      if (c == 0 || c == 6) ep = ep | 32'h40;
      chk(tag, "take", {31'b0, take_o}, 32'd1);
      chk(tag, "vector", vector_o, model_vec(c));
      chk(tag, "mode", {27'b0, mode_o}, {27'b0, model_mode(c)});
      chk(tag, "new_psr", new_psr_o, ep);
      chk(tag, "irq_mask", {31'b0, irq_mask_o}, {31'b0, ep[7]});
      chk(tag, "fiq_mask", {31'b0, fiq_mask_o}, {31'b0, ep[6]});
      chk(tag, "save_en", {31'b0, save_en_o}, (c == 0) ? 32'd0 : 32'd1);
      chk(tag, "saved_psr", saved_psr_o, (c == 0) ? 32'd0 : p);
      chk(tag, "link", link_o, (c == 0) ? 32'd0 : ra);
    end
    {req_fiq_i, req_irq_i, req_dabt_i, req_pabt_i, req_swi_i, req_undef_i, req_reset_i} = '0;
  endtask

  task automatic t_reset_state();  // R1
    chk("R1", "take in reset", {31'b0, take_o}, 32'd0);
    chk("R1", "new_psr in reset", new_psr_o, 32'd0);
    chk("R1", "link in reset", link_o, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "take after release", {31'b0, take_o}, 32'd0);
    chk("R1", "vector after release", vector_o, 32'd0);
  endtask

  task automatic t_each_source();  // R3 R5 R2
    for (int i = 0; i < 7; i++) begin
      run_case("R3", 7'(1 << i), 32'h0000_0010, 32'h100 + 32'(i * 4));
      run_case("R2", 7'b0, 32'h0000_0010, 32'h0);
    end
  endtask

  task automatic t_priority();  // R4
    run_case("R4", 7'b1111111, 32'h10, 32'h200);
    run_case("R4", 7'b1111110, 32'h10, 32'h204);
    run_case("R4", 7'b1101110, 32'h10, 32'h208);
    run_case("R4", 7'b0101110, 32'h10, 32'h20C);
    run_case("R4", 7'b0001110, 32'h10, 32'h210);
    run_case("R4", 7'b0001010, 32'h10, 32'h214);
  endtask

  task automatic t_undef_swi();  // R10
    run_case("R10", 7'b0000110, 32'h1F, 32'h300);
  endtask

  task automatic t_masking();  // R6
    run_case("R6", 7'b0100000, 32'h0000_0090, 32'h400);
    run_case("R6", 7'b1000000, 32'h0000_0050, 32'h404);
    run_case("R6", 7'b1100000, 32'h0000_0050, 32'h408);
    run_case("R6", 7'b1101000, 32'h0000_00D0, 32'h40C);
  endtask

  task automatic t_psr_update();  // R7 R8 R9
    run_case("R7", 7'b0000100, 32'hA000_0030, 32'h500);
    run_case("R7", 7'b0000100, 32'h5000_0070, 32'h504);
    run_case("R7", 7'b1000000, 32'hF000_0033, 32'h508);
    run_case("R8", 7'b0010000, 32'h6000_00B1, 32'hDEAD_BEEC);
    run_case("R9", 7'b0000001, 32'hF000_0030, 32'hCAFE_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_each_source();
    t_priority();
    t_undef_swi();
    t_masking();
    t_psr_update();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule